// File: doc/BRIEF.md
# Trimmed Seconds Counter with Alarm

This peripheral turns a fast, free-running tick strobe into a one-second event and counts those events in a 32-bit seconds register. A prescale counter advances on every input strobe. When it reaches the low half of the trim register it returns to zero and issues one seconds event, so the division ratio is trim plus one. The upper half of the trim register is kept for software but has no effect on the divider. Any write to the trim register restarts the prescaler, so a new ratio takes effect from a clean count.

On each seconds event the counter is compared with an alarm register, using the value it held before it was incremented. A match sets a sticky alarm flag when the alarm enable is on. Every seconds event also sets a sticky tick flag when the tick enable is on. The two flags and the two enables share one status register. Each flag is cleared by writing 1 to it. Two level interrupt outputs show each flag ANDed with its enable.

Software reaches the block through a simple 32-bit register bus with word offsets. It can load the seconds counter with any value, and the counter wraps from all-ones to zero.

Top module: `rtc_trim_top`

## Requirements
- R1: After reset the counter and alarm read 0, the status register reads 0, the trim register reads 0x0000_7FFF, and both interrupts are low.
- R2: A seconds event occurs once every trim[15:0]+1 input strobes. Bits 31:16 of trim are stored and read back, but they do not change the ratio.
- R3: Each seconds event adds one to the counter, and 0xFFFF_FFFF wraps to 0. Without an event or a write the counter holds its value.
- R4: Status bit 0 (alarm flag) is set on a seconds event when the counter value from before the increment equals the alarm register and status bit 2 (alarm enable) is 1. With bit 2 at 0 it is not set.
- R5: Status bit 1 (tick flag) is set on every seconds event while status bit 3 (tick enable) is 1. With bit 3 at 0 it is not set.
- R6: A status write clears bit 0 or bit 1 where the written data has a 1, leaves them unchanged where it has a 0, and loads bits 2 and 3 directly. A hardware set in the same cycle as a clear of the same flag leaves the flag set.
- R7: irq_alarm equals status bit 0 AND bit 2, and irq_tick equals status bit 1 AND bit 3. Both are registered and change in the same cycle as the status register.
- R8: A trim write resets the prescaler to 0. The first seconds event after it comes on the trim[15:0]+1-th strobe that follows the write.
- R9: A counter write loads the written value. If a seconds event falls in the same cycle, the written value wins and that increment is lost.
- R10: The register map is counter at 0x00, alarm at 0x04, status at 0x08 and trim at 0x0C. Status reads as {28'b0, bit3, bit2, bit1, bit0}. Read data is valid one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Fast input strobe that feeds the prescaler |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| irq_alarm | output | 1 | Alarm interrupt level |
| irq_tick | output | 1 | Tick interrupt level |

## Verification
Two pairs of operations can fall in the same cycle. The first is a hardware set of the tick flag together with a software write-1-to-clear of that flag. The second is a seconds event together with a software load of the counter. The bench sets up each case by first running the prescaler to one strobe short of its limit. It then issues the bus write in the same cycle as the strobe that completes the count. The results are judged by reading back the status register, which must still show the flag set, and the counter, which must show the written value with no increment applied.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int OFF_COUNT  = 'h0;
  localparam int OFF_ALARM  = 'h4;
  localparam int OFF_STATUS = 'h8;
  localparam int OFF_TRIM   = 'hC;

  localparam int ST_ALARM_FLAG = 0;
  localparam int ST_TICK_FLAG  = 1;
  localparam int ST_ALARM_EN   = 2;
  localparam int ST_TICK_EN    = 3;
  localparam int ST_W          = 4;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESC_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_in,
  input  logic               restart,
  input  logic [PRESC_W-1:0] limit,
  output logic [PRESC_W-1:0] presc_q,
  output logic               sec_tick
);
  // Event on the strobe that finds the count at its limit; a restart cancels it.
  assign sec_tick = tick_in && !restart && (presc_q == limit);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      presc_q <= '0;
    end else if (tick_in) begin
      presc_q <= (presc_q == limit) ? '0 : presc_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] alarm,
  output logic [CNT_W-1:0] count_q,
  output logic             alarm_hit
);
  // Compare uses the value held before this event's increment.
  assign alarm_hit = sec_tick && (count_q == alarm);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= load_val;
    end else if (sec_tick) begin
      count_q <= count_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_status.sv
module rtc_status
  import rtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [ST_W-1:0] wdata,
  input  logic            alarm_hit,
  input  logic            sec_tick,
  output logic [ST_W-1:0] status_q,
  output logic            irq_alarm,
  output logic            irq_tick
);
  logic [ST_W-1:0] status_n;
  logic            alarm_set;
  logic            tick_set;

  assign alarm_set = alarm_hit && status_q[ST_ALARM_EN];
  assign tick_set  = sec_tick  && status_q[ST_TICK_EN];

  always_comb begin
    status_n = status_q;
    if (wr) begin
      status_n[ST_ALARM_FLAG] = status_q[ST_ALARM_FLAG] & ~wdata[ST_ALARM_FLAG];
      status_n[ST_TICK_FLAG]  = status_q[ST_TICK_FLAG]  & ~wdata[ST_TICK_FLAG];
      status_n[ST_ALARM_EN]   = wdata[ST_ALARM_EN];
      status_n[ST_TICK_EN]    = wdata[ST_TICK_EN];
    end
    // Hardware set takes priority over a simultaneous clear.
    if (alarm_set) status_n[ST_ALARM_FLAG] = 1'b1;
    if (tick_set)  status_n[ST_TICK_FLAG]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= '0;
      irq_alarm <= 1'b0;
      irq_tick  <= 1'b0;
    end else begin
      status_q  <= status_n;
      irq_alarm <= status_n[ST_ALARM_FLAG] & status_n[ST_ALARM_EN];
      irq_tick  <= status_n[ST_TICK_FLAG]  & status_n[ST_TICK_EN];
    end
  end
endmodule

// File: rtl/rtc_trim_top.sv
module rtc_trim_top
  import rtc_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 4,
  parameter int          PRESC_W    = 16,
  parameter logic [31:0] TRIM_RESET = 32'h0000_7FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_in,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_alarm,
  output logic              irq_tick
);
  localparam int STPAD_W = DATA_W - ST_W;

  logic              sel_count, sel_alarm, sel_status, sel_trim;
  logic [DATA_W-1:0] alarm_q;
  logic [DATA_W-1:0] trim_q;
  logic [DATA_W-1:0] count_q;
  logic [PRESC_W-1:0] presc_q;
  logic [ST_W-1:0]   status_q;
  logic              sec_tick;
  logic              alarm_hit;

  assign sel_count  = (bus_addr == ADDR_W'(OFF_COUNT));
  assign sel_alarm  = (bus_addr == ADDR_W'(OFF_ALARM));
  assign sel_status = (bus_addr == ADDR_W'(OFF_STATUS));
  assign sel_trim   = (bus_addr == ADDR_W'(OFF_TRIM));

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= '0;
      trim_q  <= DATA_W'(TRIM_RESET);
    end else if (bus_wr_en) begin
      if (sel_alarm) alarm_q <= bus_wdata;
      if (sel_trim)  trim_q  <= bus_wdata;
    end
  end

  rtc_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk      (clk),
    .rst      (rst),
    .tick_in  (tick_in),
    .restart  (bus_wr_en && sel_trim),
    .limit    (trim_q[PRESC_W-1:0]),
    .presc_q  (presc_q),
    .sec_tick (sec_tick)
  );

  rtc_seconds #(.CNT_W(DATA_W)) u_secs (
    .clk       (clk),
    .rst       (rst),
    .sec_tick  (sec_tick),
    .load      (bus_wr_en && sel_count),
    .load_val  (bus_wdata),
    .alarm     (alarm_q),
    .count_q   (count_q),
    .alarm_hit (alarm_hit)
  );

  rtc_status u_stat (
    .clk       (clk),
    .rst       (rst),
    .wr        (bus_wr_en && sel_status),
    .wdata     (bus_wdata[ST_W-1:0]),
    .alarm_hit (alarm_hit),
    .sec_tick  (sec_tick),
    .status_q  (status_q),
    .irq_alarm (irq_alarm),
    .irq_tick  (irq_tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd_en) begin
      unique case (1'b1)
        sel_count:  bus_rdata <= count_q;
        sel_alarm:  bus_rdata <= alarm_q;
        sel_status: bus_rdata <= {{STPAD_W{1'b0}}, status_q};
        sel_trim:   bus_rdata <= trim_q;
        default:    bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_trim_checker.sv
module rtc_trim_checker #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int PRESC_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr_en,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               sec_tick,
  input logic [DATA_W-1:0]  count_q,
  input logic [DATA_W-1:0]  trim_q,
  input logic [PRESC_W-1:0] presc_q,
  input logic [3:0]         status_q,
  input logic               irq_alarm,
  input logic               irq_tick
);
  logic cnt_wr, st_wr;
  assign cnt_wr = bus_wr_en && (bus_addr == ADDR_W'('h0));
  assign st_wr  = bus_wr_en && (bus_addr == ADDR_W'('h8));

  a_r7_alarm_irq: assert property (@(posedge clk) disable iff (rst)
    irq_alarm == (status_q[0] && status_q[2]));
  a_r7_tick_irq: assert property (@(posedge clk) disable iff (rst)
    irq_tick == (status_q[1] && status_q[3]));
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !cnt_wr) |=> count_q == $past(count_q) + 1'b1);
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!sec_tick && !cnt_wr) |=> $stable(count_q));
  a_r5_tick_set: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && status_q[3]) |=> status_q[1]);
  a_r6_alarm_sticky: assert property (@(posedge clk) disable iff (rst)
    (status_q[0] && !(st_wr && bus_wdata[0])) |=> status_q[0]);
  a_r2_presc_bound: assert property (@(posedge clk) disable iff (rst)
    presc_q <= trim_q[PRESC_W-1:0]);
endmodule

bind rtc_trim_top rtc_trim_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRESC_W(PRESC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr_en (bus_wr_en),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .sec_tick  (sec_tick),
  .count_q   (count_q),
  .trim_q    (trim_q),
  .presc_q   (presc_q),
  .status_q  (status_q),
  .irq_alarm (irq_alarm),
  .irq_tick  (irq_tick)
);

// File: tb/rtc_trim_top_bench.sv
module rtc_trim_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_in = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic        bus_rd_en = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_alarm, irq_tick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  logic rd_pend = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_trim_top u_rtc_trim_top (
    .clk(clk), .rst(rst), .tick_in(tick_in),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_alarm(irq_alarm), .irq_tick(irq_tick)
  );

  // Monitor: read data is valid the cycle after the strobe.
  always @(posedge clk) rd_pend <= bus_rd_en;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: read got 0x%08h expected 0x%08h", t, bus_rdata, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected under %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit with_tick);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d; tick_in = with_tick;
    @(negedge clk);
    bus_wr_en = 1'b0; tick_in = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_in = 1'b1;
    end
    @(negedge clk);
    tick_in = 1'b0;
  endtask

  task automatic chk_irq(input logic ea, input logic et, input string t);
    checks++;
    if (irq_alarm !== ea || irq_tick !== et) begin
      errors++;
      $display("FAIL %s: irq alarm/tick got %b%b expected %b%b", t, irq_alarm, irq_tick, ea, et);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state, R10 map
    chk_irq(1'b0, 1'b0, "R1 irq reset");
    rd(4'h0, 32'h0, "R1 counter reset");
    rd(4'h4, 32'h0, "R1 alarm reset");
    rd(4'h8, 32'h0, "R1 status reset");
    rd(4'hC, 32'h0000_7FFF, "R10 trim reset");
    // R2 ratio 4, upper trim ignored
    wr(4'hC, 32'hABCD_0003, 0);
    rd(4'hC, 32'hABCD_0003, "R2 trim readback");
    ticks(3);
    rd(4'h0, 32'd0, "R2 no event before limit");
    ticks(1);
    rd(4'h0, 32'd1, "R2 event on 4th strobe");
    ticks(8);
    rd(4'h0, 32'd3, "R3 two more events");
    // R8 trim write restarts prescaler
    ticks(2);
    wr(4'hC, 32'h0000_0003, 0);
    ticks(3);
    rd(4'h0, 32'd3, "R8 restart delays event");
    ticks(1);
    rd(4'h0, 32'd4, "R8 event after restart");
    // R5 tick flag, R7 irq
    wr(4'h8, 32'h8, 0);
    rd(4'h8, 32'h8, "R6 enable rw");
    ticks(4);
    chk_irq(1'b0, 1'b1, "R7 tick irq");
    rd(4'h8, 32'hA, "R5 tick flag set");
    wr(4'h8, 32'hA, 0);
    chk_irq(1'b0, 1'b0, "R7 tick irq cleared");
    rd(4'h8, 32'h8, "R6 w1c tick");
    // R4 alarm uses pre-increment value
    wr(4'h4, 32'd6, 0);
    wr(4'h8, 32'h4, 0);
    ticks(4);
    rd(4'h8, 32'h4, "R4 no match 5 vs 6");
    ticks(4);
    chk_irq(1'b1, 1'b0, "R7 alarm irq");
    rd(4'h8, 32'h5, "R4 match pre-increment");
    rd(4'h0, 32'd7, "R3 counter after alarm");
    wr(4'h8, 32'h4, 0);
    rd(4'h8, 32'h5, "R6 write 0 keeps flag");
    wr(4'h8, 32'h5, 0);
    chk_irq(1'b0, 1'b0, "R7 alarm irq cleared");
    rd(4'h8, 32'h4, "R6 w1c alarm");
    // R4 disabled, R9 load
    wr(4'h8, 32'h0, 0);
    wr(4'h0, 32'd9, 0);
    wr(4'h4, 32'd9, 0);
    ticks(4);
    rd(4'h8, 32'h0, "R4 alarm enable off");
    rd(4'h0, 32'd10, "R9 load then count");
    // R3 wrap
    wr(4'h0, 32'hFFFF_FFFF, 0);
    ticks(4);
    rd(4'h0, 32'h0, "R3 wrap");
    // R6 set vs clear collision
    wr(4'h8, 32'h8, 0);
    ticks(3);
    wr(4'h8, 32'hA, 1);
    rd(4'h8, 32'hA, "R6 set wins over clear");
    rd(4'h0, 32'd1, "R3 collision event counted");
    // R9 load vs event collision
    ticks(3);
    wr(4'h0, 32'd100, 1);
    rd(4'h0, 32'd100, "R9 load wins over event");
    // R5 tick enable off
    wr(4'h8, 32'h2, 0);
    ticks(4);
    rd(4'h8, 32'h0, "R5 tick enable off");
    rd(4'h0, 32'd101, "R3 count continues");
    chk_irq(1'b0, 1'b0, "R7 irqs idle");
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10: got %0d pending reads expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule